// File: doc/BRIEF.md
# Floating-Point Register Narrow-Value Boxing Unit

This block sits beside a multi-precision floating-point register file whose entries are FLEN bits wide (128 by default). It handles single (32-bit), double (64-bit) and quad (128-bit) values. On the way into the register file it places a narrow value in the low bits of the entry and sets every bit above it to one. A value boxed this way is a negative quiet NaN when read as any wider format. The same fill is applied to loads, to moves from integer registers and to compute results.

On the way out it serves two kinds of consumer. A compute or sign-injection unit of width n first checks that the bits of the entry above n are all ones. If they are, it gets the low n bits. If any of them is zero, it gets the canonical NaN of that width. A transfer consumer, such as a store or a move to an integer register, gets the raw low n bits with no check. A full-width transfer or a full-width operation moves the whole entry unchanged. The block is purely combinational. The register array and the arithmetic are outside it.

Top module: `fp_nanbox_unit`

## Requirements
- R1: On the write side, the low n bits of `wr_boxed` equal the low n bits of `wr_val`, where n is set by `wr_fmt`: 2'b00 gives 32, 2'b01 gives 64, 2'b11 gives 128.
- R2: On the write side, when n is less than FLEN, every bit of `wr_boxed` from n up to FLEN-1 is 1. When n equals FLEN, `wr_boxed` equals `wr_val`.
- R3: Boxing nests. A single value written with FLEN=128 has bits 127:32 all set. When that entry is read as a double compute operand, the result is its 64-bit pattern, which has sign bit 63 = 1, exponent bits 62:52 all ones and quiet bit 51 = 1.
- R4: A compute read (`rd_is_compute`=1) with n < FLEN and bits FLEN-1:n of `rd_reg` all ones returns the low n bits of `rd_reg` in `rd_operand`, with the bits above n set to zero.
- R5: A compute read with n < FLEN where any of bits FLEN-1:n of `rd_reg` is zero returns the canonical NaN, zero-extended. The canonical NaN is 32'h7FC00000 for single and 64'h7FF8000000000000 for double.
- R6: A transfer read (`rd_is_compute`=0) returns the low n bits of `rd_reg` with zeros above them and applies no boxing check. When n equals FLEN, it returns `rd_reg` unchanged.
- R7: The format code 2'b10 is reserved. It is treated as full width on both sides.
- R8: A compute read at full width (n = FLEN) returns `rd_reg` unchanged for any bit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_fmt | input | 2 | Format of the value being written |
| wr_val | input | FLEN | Value to write; only the low n bits are significant |
| wr_boxed | output | FLEN | Boxed register entry to store |
| rd_fmt | input | 2 | Format the consumer expects |
| rd_is_compute | input | 1 | 1 = compute or sign-injection operand, 0 = transfer |
| rd_reg | input | FLEN | Raw register entry being read |
| rd_operand | output | FLEN | Operand for the consumer, zero-extended above n |

## Verification
The read side is tried with four kinds of entry: entries correctly boxed for the requested width, entries with a single cleared bit just above the value, entries with only the top bit cleared, and entries with no boxing at all. Together these separate a check that covers the whole upper field from one that looks at only part of it. The same invalid entries are then read as transfers, which shows that the compute and transfer paths behave differently. On the write side, values with non-ones garbage above n show that the upper field is forced to ones rather than passed through. A single value written, read back as a double, shows the nesting. The reserved format code is also exercised.

// File: rtl/fpbox_pkg.sv
// Package: shared format codes and width helpers for the boxing unit.
// Assumes a register width (FLEN) of 32, 64 or 128.
package fpbox_pkg;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_RSVD = 2'b10,
        FMT_QUAD = 2'b11
    } fp_fmt_e;

    localparam int W_SGL = 32;
    localparam int W_DBL = 64;

    // Number of narrow formats that can ever be boxed below quad.
    localparam int N_NARROW = 2;

    // Width of the narrow format at index i (0 = single, 1 = double).
    function automatic int narrow_width(input int i);
        return W_SGL << i;
    endfunction

endpackage

// File: rtl/fpbox_fill.sv
// Module: write-side boxer. It forces every bit above the format width
// to one. Assumes the low n bits of din already carry the value.
module fpbox_fill
    import fpbox_pkg::*;
#(
    parameter int FLEN = 128
) (
    input  logic [1:0]      fmt,
    input  logic [FLEN-1:0] din,
    output logic [FLEN-1:0] dout
);

    // A shift past FLEN gives an empty mask, so unsupported widths need no fill.
    localparam logic [FLEN-1:0] ALL1   = {FLEN{1'b1}};
    localparam logic [FLEN-1:0] MASK_S = ALL1 << W_SGL;
    localparam logic [FLEN-1:0] MASK_D = ALL1 << W_DBL;

    logic [FLEN-1:0] upper;

    // Pick the upper-field mask for the requested format.
    always_comb begin
        case (fmt)
            FMT_SGL: upper = MASK_S;
            FMT_DBL: upper = MASK_D;
            default: upper = '0;
        endcase
    end

    // Keep the low field and set the upper field.
    always_comb begin
        dout = (din & ~upper) | upper;
    end

endmodule

// File: rtl/fpbox_check.sv
// Module: box validity detector. Produces one flag per narrow format,
// set when every bit above that format width is one. Formats at or
// above FLEN are always flagged valid.
module fpbox_check
    import fpbox_pkg::*;
#(
    parameter int FLEN = 128
) (
    input  logic [FLEN-1:0]     entry,
    output logic [N_NARROW-1:0] box_ok
);

    localparam logic [FLEN-1:0] ALL1 = {FLEN{1'b1}};

    for (genvar gi = 0; gi < N_NARROW; gi++) begin : g_fmt
        localparam int W = narrow_width(gi);
        localparam logic [FLEN-1:0] UPPER = ALL1 << W;
        // Reduce over the upper field only; ignored bits are forced to one.
        always_comb begin
            box_ok[gi] = &(entry | ~UPPER);
        end
    end

endmodule

// File: rtl/fpbox_read.sv
// Module: read-side selector. A compute read with a bad box gets the
// canonical NaN. Any other read gets the low field, zero-extended.
// Assumes box_ok comes from fpbox_check on the same entry.
module fpbox_read
    import fpbox_pkg::*;
#(
    parameter int FLEN = 128
) (
    input  logic [1:0]          fmt,
    input  logic                is_compute,
    input  logic [FLEN-1:0]     entry,
    input  logic [N_NARROW-1:0] box_ok,
    output logic [FLEN-1:0]     operand
);

    localparam logic [FLEN-1:0] ALL1    = {FLEN{1'b1}};
    localparam logic [FLEN-1:0] MASK_S  = ALL1 << W_SGL;
    localparam logic [FLEN-1:0] MASK_D  = ALL1 << W_DBL;
    localparam logic [FLEN-1:0] CANON_S = FLEN'(32'h7FC0_0000);
    localparam logic [FLEN-1:0] CANON_D = FLEN'(64'h7FF8_0000_0000_0000);

    logic [FLEN-1:0] upper;
    logic [FLEN-1:0] canon;
    logic            ok;

    // Select the mask, validity flag and fallback NaN for the format.
    always_comb begin
        case (fmt)
            FMT_SGL: begin upper = MASK_S; ok = box_ok[0]; canon = CANON_S; end
            FMT_DBL: begin upper = MASK_D; ok = box_ok[1]; canon = CANON_D; end
            default: begin upper = '0;     ok = 1'b1;      canon = '0;      end
        endcase
    end

    // Substitute the NaN only on the compute path.
    always_comb begin
        if (is_compute && !ok) operand = canon;
        else                   operand = entry & ~upper;
    end

endmodule

// File: rtl/fp_nanbox_unit.sv
// Module: top of the boxing unit. The write side boxes values for the
// register file. The read side unboxes entries for compute or transfer
// consumers. Purely combinational; FLEN must be 32, 64 or 128.
module fp_nanbox_unit
    import fpbox_pkg::*;
#(
    parameter int FLEN = 128
) (
    input  logic [1:0]      wr_fmt,
    input  logic [FLEN-1:0] wr_val,
    output logic [FLEN-1:0] wr_boxed,
    input  logic [1:0]      rd_fmt,
    input  logic            rd_is_compute,
    input  logic [FLEN-1:0] rd_reg,
    output logic [FLEN-1:0] rd_operand
);

    logic [N_NARROW-1:0] box_ok;

    fpbox_fill #(.FLEN(FLEN)) u_fill (
        .fmt  (wr_fmt),
        .din  (wr_val),
        .dout (wr_boxed)
    );

    fpbox_check #(.FLEN(FLEN)) u_check (
        .entry  (rd_reg),
        .box_ok (box_ok)
    );

    fpbox_read #(.FLEN(FLEN)) u_read (
        .fmt        (rd_fmt),
        .is_compute (rd_is_compute),
        .entry      (rd_reg),
        .box_ok     (box_ok),
        .operand    (rd_operand)
    );

endmodule

// File: rtl/fp_nanbox_checker.sv
// Module: assertion checker for fp_nanbox_unit, attached by bind. It
// uses immediate checks because the unit has no clock. Checks are
// skipped while any input is unknown.
module fp_nanbox_checker #(
    parameter int FLEN = 128
) (
    input logic [1:0]      wr_fmt,
    input logic [FLEN-1:0] wr_val,
    input logic [FLEN-1:0] wr_boxed,
    input logic [1:0]      rd_fmt,
    input logic            rd_is_compute,
    input logic [FLEN-1:0] rd_reg,
    input logic [FLEN-1:0] rd_operand
);

    logic known;

    // Gate all checks on fully known inputs.
    always_comb begin
        known = !$isunknown({wr_fmt, wr_val, rd_fmt, rd_is_compute, rd_reg});
    end

    // Low word of the write side always follows the input.
    always_comb begin
        if (known) begin
            AST_WR_LOW_KEPT: assert (wr_boxed[31:0] == wr_val[31:0]); // R1
        end
    end

    // A transfer read never alters the low word.
    always_comb begin
        if (known && !rd_is_compute) begin
            AST_XFER_RAW_LOW: assert (rd_operand[31:0] == rd_reg[31:0]); // R6
        end
    end

    if (FLEN > 32) begin : g_sgl
        // Single write sets the whole upper field.
        always_comb begin
            if (known && wr_fmt == 2'b00) begin
                AST_WR_SGL_BOXED: assert (wr_boxed[FLEN-1:32] == {(FLEN-32){1'b1}}); // R2
            end
        end
        // Single compute read: pass when boxed, canonical NaN otherwise.
        always_comb begin
            if (known && rd_is_compute && rd_fmt == 2'b00) begin
                if (rd_reg[FLEN-1:32] == {(FLEN-32){1'b1}}) begin
                    AST_RD_SGL_PASS: assert (rd_operand == {{(FLEN-32){1'b0}}, rd_reg[31:0]}); // R4
                end else begin
                    AST_RD_SGL_CANON: assert (rd_operand == {{(FLEN-32){1'b0}}, 32'h7FC0_0000}); // R5
                end
            end
        end
    end

    if (FLEN > 64) begin : g_dbl
        // Double compute read with a broken box yields the double NaN.
        always_comb begin
            if (known && rd_is_compute && rd_fmt == 2'b01 &&
                rd_reg[FLEN-1:64] != {(FLEN-64){1'b1}}) begin
                AST_RD_DBL_CANON: assert (rd_operand == {{(FLEN-64){1'b0}}, 64'h7FF8_0000_0000_0000}); // R5
            end
        end
    end

    // Full-width formats pass straight through on both sides.
    always_comb begin
        if (known && (FLEN == 128) && rd_fmt[1]) begin
            AST_RD_FULL_RAW: assert (rd_operand == rd_reg); // R8
        end
        if (known && (FLEN == 128) && wr_fmt[1]) begin
            AST_WR_FULL_RAW: assert (wr_boxed == wr_val); // R7
        end
    end

endmodule

bind fp_nanbox_unit fp_nanbox_checker #(.FLEN(FLEN)) u_chk (
    .wr_fmt        (wr_fmt),
    .wr_val        (wr_val),
    .wr_boxed      (wr_boxed),
    .rd_fmt        (rd_fmt),
    .rd_is_compute (rd_is_compute),
    .rd_reg        (rd_reg),
    .rd_operand    (rd_operand)
);

// File: tb/sim_fp_nanbox_unit.sv
// Bench: a vector table walked by one loop, then directed checks for
// the idle state, nesting and the reserved format code.
module sim_fp_nanbox_unit;

    localparam int FLEN = 128;

    typedef struct packed {
        logic [1:0]   wfmt;
        logic [127:0] wval;
        logic [127:0] wexp;
        logic [1:0]   rfmt;
        logic         rcomp;
        logic [127:0] rreg;
        logic [127:0] rexp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R1 R2 single write with garbage above; R4 valid single compute
        '{2'b00, 128'h01234567_89ABCDEF_11112222_3F800000, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_3F800000,
          2'b00, 1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_40490FDB, 128'h00000000_00000000_00000000_40490FDB},
        // R2 double write; R5 single compute with bit 32 cleared
        '{2'b01, 128'hAAAAAAAA_AAAAAAAA_400921FB_54442D18, 128'hFFFFFFFF_FFFFFFFF_400921FB_54442D18,
          2'b00, 1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFE_3F800000, 128'h00000000_00000000_00000000_7FC00000},
        // R2 quad write raw; R4 valid double compute
        '{2'b11, 128'h00000000_00000000_00000000_00001234, 128'h00000000_00000000_00000000_00001234,
          2'b01, 1'b1, 128'hFFFFFFFF_FFFFFFFF_C0000000_00000000, 128'h00000000_00000000_C0000000_00000000},
        // R2 single write zero; R5 double compute with top bit cleared
        '{2'b00, 128'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000,
          2'b01, 1'b1, 128'h7FFFFFFF_FFFFFFFF_00000000_00000001, 128'h00000000_00000000_7FF80000_00000000},
        // R2 double write zero; R6 single transfer ignores bad box
        '{2'b01, 128'h0, 128'hFFFFFFFF_FFFFFFFF_00000000_00000000,
          2'b00, 1'b0, 128'h00000000_00000000_00000000_DEADBEEF, 128'h00000000_00000000_00000000_DEADBEEF},
        // R6 double transfer of a boxed single keeps the box bits
        '{2'b00, 128'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000,
          2'b01, 1'b0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_3F800000, 128'h00000000_00000000_FFFFFFFF_3F800000},
        // R6 quad transfer is raw
        '{2'b00, 128'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000,
          2'b11, 1'b0, 128'h01234567_89ABCDEF_FEDCBA98_76543210, 128'h01234567_89ABCDEF_FEDCBA98_76543210},
        // R8 quad compute passes any pattern
        '{2'b00, 128'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000,
          2'b11, 1'b1, 128'h00001111_22223333_00000000_00000000, 128'h00001111_22223333_00000000_00000000},
        // R7 reserved code acts as full width on both sides
        '{2'b10, 128'h00000000_00000000_00000000_00000005, 128'h00000000_00000000_00000000_00000005,
          2'b10, 1'b1, 128'h00000000_00000000_00000000_00000005, 128'h00000000_00000000_00000000_00000005}
    };

    logic             clk;
    logic             rst_n;
    logic [1:0]       wr_fmt;
    logic [FLEN-1:0]  wr_val;
    logic [FLEN-1:0]  wr_boxed;
    logic [1:0]       rd_fmt;
    logic             rd_is_compute;
    logic [FLEN-1:0]  rd_reg;
    logic [FLEN-1:0]  rd_operand;

    int total;
    int bad;
    bit done;

    fp_nanbox_unit #(.FLEN(FLEN)) u0 (
        .wr_fmt        (wr_fmt),
        .wr_val        (wr_val),
        .wr_boxed      (wr_boxed),
        .rd_fmt        (rd_fmt),
        .rd_is_compute (rd_is_compute),
        .rd_reg        (rd_reg),
        .rd_operand    (rd_operand)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Compare one value and log a mismatch.
    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total = 0;
        bad = 0;
        done = 0;
        rst_n = 1'b0;
        wr_fmt = 2'b00;
        wr_val = '0;
        rd_fmt = 2'b00;
        rd_is_compute = 1'b0;
        rd_reg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Idle state: zero single write is a boxed zero; zero transfer is zero.
        check("R2 idle write", wr_boxed, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000);
        check("R6 idle read", rd_operand, 128'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            wr_fmt        = VECS[i].wfmt;
            wr_val        = VECS[i].wval;
            rd_fmt        = VECS[i].rfmt;
            rd_is_compute = VECS[i].rcomp;
            rd_reg        = VECS[i].rreg;
            @(negedge clk);
            check($sformatf("R1/R2 write vec %0d", i), wr_boxed, VECS[i].wexp);
            check($sformatf("R4/R5/R6 read vec %0d", i), rd_operand, VECS[i].rexp);
        end

        // R3: a single written, then read back as a double compute operand.
        @(posedge clk);
        wr_fmt = 2'b00;
        wr_val = 128'h55555555_55555555_55555555_12345678;
        @(negedge clk);
        check("R3 nested write", wr_boxed, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_12345678);
        @(posedge clk);
        rd_reg = wr_boxed;
        rd_fmt = 2'b01;
        rd_is_compute = 1'b1;
        @(negedge clk);
        check("R3 read as double", rd_operand, 128'h00000000_00000000_FFFFFFFF_12345678);
        check("R3 negative quiet NaN", {125'h0, rd_operand[63], &rd_operand[62:52], rd_operand[51]}, 128'h7);
        @(posedge clk);
        rd_fmt = 2'b00;
        @(negedge clk);
        check("R3 read as single", rd_operand, 128'h12345678);

        // R5: a bad box on a single compute read yields NaN, not the low bits.
        @(posedge clk);
        rd_reg = 128'h00000000_00000000_00000000_3F800000;
        @(negedge clk);
        check("R5 unboxed single", rd_operand, 128'h7FC00000);
        // R6: the same entry read as a transfer gives the raw low bits.
        @(posedge clk);
        rd_is_compute = 1'b0;
        @(negedge clk);
        check("R6 unboxed single transfer", rd_operand, 128'h3F800000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule